// File: doc/BRIEF.md
# Quad wiper register bank

This block keeps the register state of a four-channel digital potentiometer controller and carries out already-decoded commands on it. Every channel owns one volatile 8-bit wiper register, whose value leaves the block as an 8-bit tap select, and four 8-bit storage registers that stand in for non-volatile memory. A bus front end presents each command for one clock on a strobe, with a 4-bit opcode, a storage-register index, a channel index and a data byte.

Reads return a byte with a one-cycle valid flag. Any command that programs a storage register opens a modelled programming window of `PROG_CYCLES` clocks, and `busy` is high for that window. Commands that arrive while `busy` is high are dropped, as are storage-register programs attempted while the protect input is low. Either case raises a one-cycle `reject` pulse, so the front end can withhold its acknowledge. The storage registers keep their contents across reset. Leaving reset copies each channel's storage register 0 into its wiper.

Top module: `potbank`

## Requirements
- R1: After reset, `busy`, `reject` and `rd_valid` are low, and each channel's tap output equals that channel's storage register 0. Storage contents written before the reset survive it.
- R2: Opcode 4'b1010 loads `cmd_data` into the wiper of channel `cmd_ch`, and the tap output shows it one clock later. The other channels and `busy` are unaffected.
- R3: Opcode 4'b1001 returns the wiper of `cmd_ch`, and opcode 4'b1011 returns storage register `cmd_reg` of `cmd_ch`. In both cases `rd_data` is valid, with `rd_valid` high, for the one cycle after the command.
- R4: Opcode 4'b1100 stores `cmd_data` into storage register `cmd_reg` of channel `cmd_ch`. `busy` rises on the clock after the command and stays high for exactly `PROG_CYCLES` cycles.
- R5: Opcode 4'b1101 copies storage register `cmd_reg` of `cmd_ch` into that channel's wiper without raising `busy`. Opcode 4'b1110 copies the wiper of `cmd_ch` into its storage register `cmd_reg` and starts a programming window.
- R6: Opcode 4'b0001 copies storage register `cmd_reg` of every channel into that channel's wiper in one clock, without raising `busy`.
- R7: Opcode 4'b1000 copies every channel's wiper into its storage register `cmd_reg` in one clock and starts a programming window.
- R8: A command presented while `busy` is high is dropped, with no change to any register, and `reject` is high for the following cycle.
- R9: While `wp_n` is low, opcodes 4'b1100, 4'b1110 and 4'b1000 leave the storage registers unchanged, do not raise `busy`, and pulse `reject`. Wiper writes and transfers into the wipers still take effect.
- R10: If `wp_n` falls after a programming window has started, the window runs its full length and the programmed byte is kept.
- R11: Opcodes outside the set above, 4'b0101 and 4'b0010 among them, change no register and raise neither `busy` nor `reject`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; triggers the recall into the wipers |
| wp_n | input | 1 | Protect input; low blocks programming of the storage registers |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Opcode |
| cmd_reg | input | $clog2(NREG) | Storage register index |
| cmd_ch | input | $clog2(NCH) | Channel index |
| cmd_data | input | W | Data byte for writes |
| tap_sel | output | NCH*W | Wiper values, channel 0 in the low byte |
| rd_data | output | W | Read result |
| rd_valid | output | 1 | One-cycle flag marking `rd_data` valid |
| busy | output | 1 | High during a programming window |
| reject | output | 1 | One-cycle pulse for a dropped or refused command |

## Verification
The protect input falling inside a programming window already in progress is the hardest case to reach from the ports. The bench issues a storage write with `wp_n` high. It drops `wp_n` two cycles into the window and then counts the cycles for which `busy` stays high. It reads the byte back with the protect input still low. The power-up recall is also hard to reach, because it needs storage contents that persist across reset. Every channel's storage register 0 is programmed, reset is pulsed in the middle of the run, and the tap outputs are compared against the stored bytes.

// File: rtl/potbank.sv
module potbank #(
  parameter int NCH = 4,
  parameter int NREG = 4,
  parameter int W = 8,
  parameter int PROG_CYCLES = 250000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wp_n,
  input  logic                     cmd_valid,
  input  logic [3:0]               cmd_op,
  input  logic [$clog2(NREG)-1:0]  cmd_reg,
  input  logic [$clog2(NCH)-1:0]   cmd_ch,
  input  logic [W-1:0]             cmd_data,
  output logic [NCH*W-1:0]         tap_sel,
  output logic [W-1:0]             rd_data,
  output logic                     rd_valid,
  output logic                     busy,
  output logic                     reject
);
  localparam int CW = $clog2(NCH);
  localparam int RW = $clog2(NREG);
  localparam int BW = $clog2(PROG_CYCLES + 1);

  localparam logic [3:0] OP_RD_WIP = 4'b1001;
  localparam logic [3:0] OP_WR_WIP = 4'b1010;
  localparam logic [3:0] OP_RD_STO = 4'b1011;
  localparam logic [3:0] OP_WR_STO = 4'b1100;
  localparam logic [3:0] OP_STO2W  = 4'b1101;
  localparam logic [3:0] OP_W2STO  = 4'b1110;
  localparam logic [3:0] OP_GSTO2W = 4'b0001;
  localparam logic [3:0] OP_GW2STO = 4'b1000;

  logic [W-1:0]  wiper [NCH];
  logic [W-1:0]  store [NCH][NREG];
  logic [BW-1:0] prog_cnt;

  logic take, nv_op, nv_go, refuse, is_read;

  assign busy    = prog_cnt != '0;
  assign take    = cmd_valid && !busy;
  assign nv_op   = cmd_op == OP_WR_STO || cmd_op == OP_W2STO || cmd_op == OP_GW2STO;
  assign nv_go   = rst_n && take && nv_op && wp_n;
  assign refuse  = cmd_valid && (busy || (nv_op && !wp_n));
  assign is_read = cmd_op == OP_RD_WIP || cmd_op == OP_RD_STO;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_tap
      assign tap_sel[g*W +: W] = wiper[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        wiper[c] <= store[c][0];
      end else if (take) begin
        case (cmd_op)
          OP_WR_WIP: if (cmd_ch == CW'(c)) wiper[c] <= cmd_data;
          OP_STO2W:  if (cmd_ch == CW'(c)) wiper[c] <= store[c][cmd_reg];
          OP_GSTO2W: wiper[c] <= store[c][cmd_reg];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < NREG; r++) begin
        if (nv_go && cmd_reg == RW'(r)) begin
          case (cmd_op)
            OP_WR_STO: if (cmd_ch == CW'(c)) store[c][r] <= cmd_data;
            OP_W2STO:  if (cmd_ch == CW'(c)) store[c][r] <= wiper[c];
            OP_GW2STO: store[c][r] <= wiper[c];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          prog_cnt <= '0;
    else if (nv_go)      prog_cnt <= BW'(PROG_CYCLES);
    else if (busy)       prog_cnt <= prog_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      reject   <= 1'b0;
    end else begin
      rd_valid <= take && is_read;
      reject   <= refuse;
      if (take && is_read)
        rd_data <= (cmd_op == OP_RD_WIP) ? wiper[cmd_ch] : store[cmd_ch][cmd_reg];
    end
  end
endmodule

// File: rtl/potbank_chk.sv
module potbank_chk #(
  parameter int NCH = 4,
  parameter int NREG = 4,
  parameter int W = 8,
  parameter int PROG_CYCLES = 250000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wp_n,
  input logic                    cmd_valid,
  input logic [3:0]              cmd_op,
  input logic [$clog2(NREG)-1:0] cmd_reg,
  input logic [$clog2(NCH)-1:0]  cmd_ch,
  input logic [W-1:0]            cmd_data,
  input logic [NCH*W-1:0]        tap_sel,
  input logic [W-1:0]            rd_data,
  input logic                    rd_valid,
  input logic                    busy,
  input logic                    reject
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && busy_run != 0) |-> busy_run == PROG_CYCLES);

  // R4
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_run < PROG_CYCLES);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> (reject && $stable(tap_sel)));

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !wp_n && cmd_op == 4'b1100) |=> (reject && !busy));

  // R3
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !busy && (cmd_op == 4'b1001 || cmd_op == 4'b1011)));

  // R2
  wr_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 4'b1010)
      |=> tap_sel[int'($past(cmd_ch))*W +: W] == $past(cmd_data));

  // R11
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 4'b0101) |=> (!reject && !busy && $stable(tap_sel)));
endmodule

bind potbank potbank_chk #(.NCH(NCH), .NREG(NREG), .W(W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_reg(cmd_reg), .cmd_ch(cmd_ch), .cmd_data(cmd_data), .tap_sel(tap_sel),
  .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .reject(reject)
);

// File: tb/tb_potbank.sv
module tb_potbank;
  localparam int CLK_P = 10;
  localparam int PROG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_reg = '0;
  logic [1:0] cmd_ch = '0;
  logic [7:0] cmd_data = '0;
  logic [31:0] tap_sel;
  logic [7:0] rd_data;
  logic rd_valid, busy, reject;

  int errors = 0;
  int checks = 0;
  logic [7:0] ew [4];
  logic [7:0] ed [4][4];

  always #(CLK_P/2) clk = ~clk;

  potbank #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_ch(cmd_ch), .cmd_data(cmd_data), .tap_sel(tap_sel),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .reject(reject)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [1:0] r, input logic [1:0] c,
                      input logic [7:0] d);
    @(negedge clk);
    cmd_op = op; cmd_reg = r; cmd_ch = c; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic taps(input string tag);
    for (int c = 0; c < 4; c++) chk(tap_sel[c*8 +: 8], ew[c], tag);
  endtask

  task automatic read_sto(input logic [1:0] c, input logic [1:0] r, input string tag);
    send(4'b1011, r, c, 8'h00);
    chk(rd_valid, 1, tag);
    chk(rd_data, ed[c][r], tag);
  endtask

  task automatic wr_sto(input logic [1:0] c, input logic [1:0] r, input logic [7:0] d);
    int n;
    send(4'b1100, r, c, d);
    ed[c][r] = d;
    busy_len(n);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy, 0, "R1 busy");
    chk(reject, 0, "R1 reject");
    chk(rd_valid, 0, "R1 rd_valid");
  endtask

  task automatic t_write_wiper;
    for (int c = 0; c < 4; c++) begin
      send(4'b1010, 2'd0, 2'(c), 8'(8'h10 + c));
      ew[c] = 8'(8'h10 + c);
    end
    send(4'b1010, 2'd0, 2'd2, 8'h5A);
    ew[2] = 8'h5A;
    taps("R2 tap");
    chk(busy, 0, "R2 busy");
  endtask

  task automatic t_read_wiper;
    send(4'b1001, 2'd3, 2'd2, 8'hFF);
    chk(rd_valid, 1, "R3 rd_valid");
    chk(rd_data, 8'h5A, "R3 wiper read");
    @(negedge clk);
    chk(rd_valid, 0, "R3 rd_valid single");
  endtask

  task automatic t_write_sto;
    int n;
    send(4'b1100, 2'd3, 2'd1, 8'hC3);
    ed[1][3] = 8'hC3;
    busy_len(n);
    chk(n, PROG, "R4 busy length");
    read_sto(2'd1, 2'd3, "R4 stored");
  endtask

  task automatic t_single_xfer;
    int n;
    wr_sto(2'd0, 2'd2, 8'h11);
    send(4'b1101, 2'd2, 2'd0, 8'h00);
    ew[0] = 8'h11;
    chk(busy, 0, "R5 no busy");
    taps("R5 sto to wiper");
    send(4'b1010, 2'd0, 2'd3, 8'h77);
    ew[3] = 8'h77;
    send(4'b1110, 2'd1, 2'd3, 8'h00);
    ed[3][1] = 8'h77;
    busy_len(n);
    chk(n, PROG, "R5 busy length");
    read_sto(2'd3, 2'd1, "R5 wiper to sto");
  endtask

  task automatic t_gang_load;
    for (int c = 0; c < 3; c++) wr_sto(2'(c), 2'd1, 8'(8'hA0 + c));
    send(4'b0001, 2'd1, 2'd2, 8'h00);
    for (int c = 0; c < 4; c++) ew[c] = ed[c][1];
    chk(busy, 0, "R6 no busy");
    taps("R6 gang load");
  endtask

  task automatic t_gang_store;
    int n;
    for (int c = 0; c < 4; c++) begin
      send(4'b1010, 2'd0, 2'(c), 8'(8'h30 + 3*c));
      ew[c] = 8'(8'h30 + 3*c);
    end
    send(4'b1000, 2'd2, 2'd1, 8'h00);
    for (int c = 0; c < 4; c++) ed[c][2] = ew[c];
    busy_len(n);
    chk(n, PROG, "R7 busy length");
    for (int c = 0; c < 4; c++) read_sto(2'(c), 2'd2, "R7 gang store");
  endtask

  task automatic t_busy_drop;
    int n;
    send(4'b1100, 2'd0, 2'd3, 8'h3C);
    ed[3][0] = 8'h3C;
    chk(reject, 0, "R8 accepted");
    send(4'b1010, 2'd0, 2'd1, 8'hEE);
    chk(reject, 1, "R8 reject");
    taps("R8 tap kept");
    @(negedge clk);
    chk(reject, 0, "R8 reject single");
    busy_len(n);
    send(4'b1001, 2'd0, 2'd1, 8'h00);
    chk(rd_data, ew[1], "R8 wiper kept");
  endtask

  task automatic t_protect;
    wp_n = 1'b0;
    send(4'b1100, 2'd3, 2'd1, 8'h99);
    chk(reject, 1, "R9 reject");
    chk(busy, 0, "R9 no busy");
    send(4'b1110, 2'd3, 2'd1, 8'h00);
    chk(reject, 1, "R9 xfer reject");
    send(4'b1000, 2'd3, 2'd0, 8'h00);
    chk(reject, 1, "R9 gang reject");
    read_sto(2'd1, 2'd3, "R9 sto kept");
    for (int c = 0; c < 4; c++) read_sto(2'(c), 2'd3 - 2'(c == 1 ? 0 : 0), "R9 sto row kept");
    send(4'b1010, 2'd0, 2'd0, 8'h42);
    ew[0] = 8'h42;
    chk(reject, 0, "R9 wiper allowed");
    taps("R9 wiper write");
    wp_n = 1'b1;
  endtask

  task automatic t_protect_late;
    int n;
    send(4'b1100, 2'd0, 2'd2, 8'h5E);
    ed[2][0] = 8'h5E;
    @(negedge clk);
    wp_n = 1'b0;
    busy_len(n);
    chk(n, PROG - 1, "R10 busy remaining");
    read_sto(2'd2, 2'd0, "R10 kept");
    wp_n = 1'b1;
  endtask

  task automatic t_unknown;
    send(4'b0101, 2'd1, 2'd0, 8'hAB);
    chk(reject, 0, "R11 reject");
    chk(busy, 0, "R11 busy");
    send(4'b0010, 2'd1, 2'd0, 8'hAB);
    chk(reject, 0, "R11 reject 0010");
    taps("R11 taps");
    read_sto(2'd0, 2'd1, "R11 sto");
  endtask

  task automatic t_recall;
    wr_sto(2'd0, 2'd0, 8'hD0);
    wr_sto(2'd1, 2'd0, 8'hD1);
    for (int c = 0; c < 4; c++) ew[c] = ed[c][0];
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    taps("R1 recall");
    chk(busy, 0, "R1 busy after recall");
    read_sto(2'd1, 2'd3, "R1 storage retained");
  endtask

  bit done = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_wiper();
    t_read_wiper();
    t_write_sto();
    t_single_xfer();
    t_gang_load();
    t_gang_store();
    t_busy_drop();
    t_protect();
    t_protect_late();
    t_unknown();
    t_recall();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule